// File: doc/BRIEF.md
# Three-Phase Signed Current Window and Sign Monitor

This block watches three signed current samples, one per motor phase, and keeps two decisions for each phase. The first is a polarity flag that reports whether the current is flowing in the positive or negative direction. The second is an active-high "in range" flag. It drops low when the sample leaves a window that is symmetric about zero. Both decisions carry hysteresis, so a sample that sits near a threshold does not make the outputs toggle on every new sample.

The window limit comes from an 8-bit unsigned code. The code is scaled to sample units by a fixed left shift of `LIM_SHIFT` bits, which gives limit `L = code << LIM_SHIFT`. The negative limit is always `-L`. The polarity hysteresis and the window hysteresis are set independently, in sample LSBs. Phase currents normally use a small polarity hysteresis, about one fifth of that used for position-sensor signs.

Each phase holds two two-state machines. The polarity machine has the states `SGN_NEG` and `SGN_POS`. It takes the transition *rise* from `SGN_NEG` to `SGN_POS` and the transition *fall* from `SGN_POS` to `SGN_NEG`. The window machine has the states `WIN_INSIDE` and `WIN_TRIPPED`. It takes the transition *trip* from `WIN_INSIDE` to `WIN_TRIPPED` and the transition *release* from `WIN_TRIPPED` to `WIN_INSIDE`. A machine can only move on a cycle where the valid strobe is high.

Top module: `phase_window_monitor`

## Requirements
- R1: While reset is asserted and after it is released, and before any valid sample arrives, `pol_out` is 000 and `in_range` is 111.
- R2: On a cycle with `smp_valid` low, no output changes, whatever the other inputs are.
- R3: A polarity flag at 0 goes to 1 only when a valid sample is strictly greater than `pol_hyst`. A sample equal to `pol_hyst` leaves it at 0.
- R4: A polarity flag at 1 goes to 0 only when a valid sample is strictly less than `-pol_hyst`. A sample equal to `-pol_hyst` leaves it at 1.
- R5: An `in_range` flag at 1 goes to 0 when a valid sample is greater than `L` or less than `-L`, where `L = lim_code << LIM_SHIFT`. A sample of exactly `L` or `-L` keeps it at 1.
- R6: An `in_range` flag at 0 returns to 1 only when a valid sample lies in `[-Rl, Rl]`, where `Rl = L - win_hyst` if `L > win_hyst` and `Rl = 0` otherwise. Otherwise it stays at 0.
- R7: With `lim_code` equal to 0 and a zero sample, an `in_range` flag at 1 stays at 1.
- R8: The phases are independent. Phase i reads `smp_bus[i*SMP_W +: SMP_W]` as two's complement and drives bit i of `pol_out` and bit i of `in_range`.
- R9: A valid sample taken at a rising clock edge is reflected on the outputs right after that same edge. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: the samples on `smp_bus` are new |
| smp_bus | input | NPH*SMP_W (36) | Packed signed samples, phase i at bits i*SMP_W upward |
| lim_code | input | CODE_W (8) | Unsigned window limit code |
| pol_hyst | input | HYST_W (8) | Polarity hysteresis in sample LSBs |
| win_hyst | input | HYST_W (8) | Window release hysteresis in sample LSBs |
| pol_out | output | NPH (3) | Per-phase polarity flag, 1 = positive |
| in_range | output | NPH (3) | Per-phase window flag, 0 = out of window |

## Verification
Every result is due one clock edge after the stimulus. The bench changes inputs on the falling edge, and the rising edge that follows captures any valid sample. The bench compares the outputs at the next falling edge, after the only register stage has updated and before new inputs are applied. Its reference model advances its own per-phase polarity and window state only on a strobed step, at that same edge. Directed steps sit exactly on each threshold and one LSB past it, and a seeded random run follows.

// File: rtl/ocm_pkg.sv
package ocm_pkg;

    typedef enum logic {
        SGN_NEG = 1'b0,
        SGN_POS = 1'b1
    } sgn_state_t;

    typedef enum logic {
        WIN_INSIDE  = 1'b0,
        WIN_TRIPPED = 1'b1
    } win_state_t;

    function automatic int ocm_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ocm_limit_scale.sv
module ocm_limit_scale #(
    parameter int CODE_W    = 8,
    parameter int HYST_W    = 8,
    parameter int LIM_SHIFT = 3,
    parameter int EXT_W     = 14
) (
    input  logic [CODE_W-1:0]        lim_code,
    input  logic [HYST_W-1:0]        win_hyst,
    output logic signed [EXT_W-1:0]  trip_lim,
    output logic signed [EXT_W-1:0]  rel_lim
);

    logic signed [EXT_W-1:0] hyst_ext;

    always_comb begin
        trip_lim = signed'(EXT_W'(lim_code) << LIM_SHIFT);
        hyst_ext = signed'(EXT_W'(win_hyst));
        if (trip_lim > hyst_ext) begin
            rel_lim = trip_lim - hyst_ext;
        end else begin
            rel_lim = '0;
        end
    end

endmodule

// File: rtl/ocm_sign_fsm.sv
module ocm_sign_fsm
    import ocm_pkg::*;
#(
    parameter int EXT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic signed [EXT_W-1:0] sample,
    input  logic signed [EXT_W-1:0] hyst,
    output logic                    sign_o
);

    sgn_state_t state_q, state_d;
    logic signed [EXT_W-1:0] neg_hyst;

    assign neg_hyst = -hyst;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SGN_NEG;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: rise and fall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SGN_NEG: if (valid && (sample > hyst))     state_d = SGN_POS;
            SGN_POS: if (valid && (sample < neg_hyst)) state_d = SGN_NEG;
            default: state_d = SGN_NEG;
        endcase
    end

    // outputs
    always_comb begin
        sign_o = (state_q == SGN_POS);
    end

    assert_sign_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(sign_o));

    assert_sign_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sign_o) |-> ($past(valid) && ($past(sample) > $past(hyst))));

    assert_sign_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sign_o) |-> ($past(valid) && ($past(sample) < $past(neg_hyst))));

endmodule

// File: rtl/ocm_window_fsm.sv
module ocm_window_fsm
    import ocm_pkg::*;
#(
    parameter int EXT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic signed [EXT_W-1:0] sample,
    input  logic signed [EXT_W-1:0] trip_lim,
    input  logic signed [EXT_W-1:0] rel_lim,
    output logic                    ok_o
);

    win_state_t state_q, state_d;
    logic signed [EXT_W-1:0] neg_trip;
    logic signed [EXT_W-1:0] neg_rel;
    logic outside;
    logic settled;

    assign neg_trip = -trip_lim;
    assign neg_rel  = -rel_lim;
    assign outside  = (sample > trip_lim) || (sample < neg_trip);
    assign settled  = (sample <= rel_lim) && (sample >= neg_rel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_INSIDE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: trip and release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_INSIDE:  if (valid && outside) state_d = WIN_TRIPPED;
            WIN_TRIPPED: if (valid && settled) state_d = WIN_INSIDE;
            default:     state_d = WIN_INSIDE;
        endcase
    end

    // outputs
    always_comb begin
        ok_o = (state_q == WIN_INSIDE);
    end

    assert_win_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(ok_o));

    assert_win_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ok_o) |-> ($past(valid) &&
            (($past(sample) > $past(trip_lim)) || ($past(sample) < $past(neg_trip)))));

    assert_win_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> ($past(valid) &&
            ($past(sample) <= $past(rel_lim)) && ($past(sample) >= $past(neg_rel))));

    assert_win_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (trip_lim == '0) && (sample == '0) && ok_o) |=> ok_o);

endmodule

// File: rtl/phase_window_monitor.sv
module phase_window_monitor
    import ocm_pkg::*;
#(
    parameter int NPH       = 3,
    parameter int SMP_W     = 12,
    parameter int CODE_W    = 8,
    parameter int HYST_W    = 8,
    parameter int LIM_SHIFT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [NPH*SMP_W-1:0]   smp_bus,
    input  logic [CODE_W-1:0]      lim_code,
    input  logic [HYST_W-1:0]      pol_hyst,
    input  logic [HYST_W-1:0]      win_hyst,
    output logic [NPH-1:0]         pol_out,
    output logic [NPH-1:0]         in_range
);

    localparam int EXT_W = ocm_max3(SMP_W, CODE_W + LIM_SHIFT, HYST_W) + 2;

    logic signed [EXT_W-1:0] trip_lim;
    logic signed [EXT_W-1:0] rel_lim;
    logic signed [EXT_W-1:0] pol_h_ext;

    assign pol_h_ext = signed'(EXT_W'(pol_hyst));

    ocm_limit_scale #(
        .CODE_W    (CODE_W),
        .HYST_W    (HYST_W),
        .LIM_SHIFT (LIM_SHIFT),
        .EXT_W     (EXT_W)
    ) u_lim (
        .lim_code (lim_code),
        .win_hyst (win_hyst),
        .trip_lim (trip_lim),
        .rel_lim  (rel_lim)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        logic signed [EXT_W-1:0] smp_ext;

        assign smp_ext = EXT_W'(signed'(smp_bus[g*SMP_W +: SMP_W]));

        ocm_sign_fsm #(.EXT_W(EXT_W)) u_sign (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid  (smp_valid),
            .sample (smp_ext),
            .hyst   (pol_h_ext),
            .sign_o (pol_out[g])
        );

        ocm_window_fsm #(.EXT_W(EXT_W)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (smp_valid),
            .sample   (smp_ext),
            .trip_lim (trip_lim),
            .rel_lim  (rel_lim),
            .ok_o     (in_range[g])
        );
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pol_out == '0) && (in_range == '1));

endmodule

// File: tb/sim_phase_window_monitor.sv
module sim_phase_window_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int NPH   = 3;
    localparam int SMP_W = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic [NPH*SMP_W-1:0] smp_bus = '0;
    logic [7:0]           lim_code = '0;
    logic [7:0]           pol_hyst = '0;
    logic [7:0]           win_hyst = '0;
    logic [NPH-1:0]       pol_out;
    logic [NPH-1:0]       in_range;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit m_sign [NPH];
    bit m_ok   [NPH];

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_window_monitor u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_bus   (smp_bus),
        .lim_code  (lim_code),
        .pol_hyst  (pol_hyst),
        .win_hyst  (win_hyst),
        .pol_out   (pol_out),
        .in_range  (in_range)
    );

    function automatic bit exp_sign(bit prev, int x, int h);
        if (!prev) return (x > h);
        return !(x < -h);
    endfunction

    function automatic bit exp_ok(bit prev, int x, int lim, int wh);
        int rl;
        if (prev) return !((x > lim) || (x < -lim));
        rl = (lim > wh) ? lim - wh : 0;
        return (x <= rl) && (x >= -rl);
    endfunction

    task automatic check_outputs(string tag);
        logic [NPH-1:0] es, eo;
        for (int i = 0; i < NPH; i++) begin
            es[i] = m_sign[i];
            eo[i] = m_ok[i];
        end
        checks++;
        if (pol_out !== es || in_range !== eo) begin
            errors++;
            $display("FAIL %s: pol_out=%b in_range=%b expected pol_out=%b in_range=%b",
                     tag, pol_out, in_range, es, eo);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(string tag, bit v, int p0, int p1, int p2,
                        int code, int sh, int wh);
        int xs [NPH];
        xs[0] = p0; xs[1] = p1; xs[2] = p2;
        smp_valid = v;
        lim_code  = 8'(code);
        pol_hyst  = 8'(sh);
        win_hyst  = 8'(wh);
        for (int i = 0; i < NPH; i++) smp_bus[i*SMP_W +: SMP_W] = SMP_W'(xs[i]);
        @(posedge clk);
        if (v) begin
            for (int i = 0; i < NPH; i++) begin
                m_sign[i] = exp_sign(m_sign[i], xs[i], sh);
                m_ok[i]   = exp_ok(m_ok[i], xs[i], code * 8, wh);
            end
        end
        @(negedge clk);
        check_outputs(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        for (int i = 0; i < NPH; i++) begin
            m_sign[i] = 1'b0;
            m_ok[i]   = 1'b1;
        end
        repeat (3) @(negedge clk);
        check_outputs("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 after reset");

        // R7: zero code, zero samples
        step("R7", 1, 0, 0, 0, 0, 0, 0);
        // R3: polarity threshold at hysteresis
        step("R3 equal", 1, 5, 0, 0, 10, 5, 4);
        step("R3 above", 1, 6, 0, 0, 10, 5, 4);
        // R4: polarity falls only below -hyst
        step("R4 equal", 1, -5, 0, 0, 10, 5, 4);
        step("R4 below", 1, -6, 0, 0, 10, 5, 4);
        // R5: window limit L = 80
        step("R5 at limit", 1, 80, -80, 0, 10, 5, 4);
        step("R5 above", 1, 81, -81, 0, 10, 5, 4);
        // R6: release band Rl = 76
        step("R6 outside band", 1, 77, -77, 0, 10, 5, 4);
        step("R6 in band", 1, 76, -76, 0, 10, 5, 4);
        // R6: hysteresis larger than limit leaves only zero
        step("R6 trip small", 1, 9, 0, 0, 1, 0, 20);
        step("R6 tiny band", 1, 1, 0, 0, 1, 0, 20);
        step("R6 zero release", 1, 0, 0, 0, 1, 0, 20);
        // R2: strobe low, large values ignored
        step("R2 hold", 0, 2000, -2000, 2000, 0, 0, 0);
        step("R2 hold again", 0, -2000, 2000, -2000, 0, 0, 0);
        // R8: only phase 2 sees a fault and polarity
        step("R8 phase 2", 1, 0, 0, 100, 10, 0, 0);
        step("R8 extremes", 1, 2047, -2048, 0, 255, 0, 0);
        step("R5 extreme neg", 1, -2048, 2047, 0, 200, 0, 0);

        // R9: random run, each result due one edge after its strobe
        for (int n = 0; n < 3000; n++) begin
            int code, sh, wh, a, b, c;
            bit v;
            code = int'($urandom % 64);
            sh   = int'($urandom % 32);
            wh   = int'($urandom % 32);
            v    = ($urandom % 4) != 0;
            a    = int'($urandom % 1400) - 700;
            b    = int'($urandom % 1400) - 700;
            c    = int'($urandom % 200) - 100;
            step("R9 random", v, a, b, c, code, sh, wh);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule